// File: doc/BRIEF.md
# Configurable External Interrupt Input

This block turns an external active-low interrupt pin into a request for the chip's interrupt logic. The pin is first passed through a two-flop synchronizer. A control bit then picks how a request is recognised. With the bit clear, a low level on the pin asks for service for as long as it lasts. With the bit set, a falling edge on the pin is caught in a latch. The latch holds the request until an acknowledge strobe clears it or reset arrives.

A second control bit enables the interrupt function. When it is clear, the pin is cut off from the request and the edge latch is held empty. The synchronized pin value is always available on a separate readback output, so the pin can serve as a general-purpose input whether or not the interrupt function is on. A mode-class input sets how the edge-select bit may be written. In special modes it may be written at any time. In normal and emulation modes it may be written only once after reset.

Top module: `irq_input_cond`

## Requirements
- R1: After reset the control readback is 0x40 (enable bit 6 = 1, edge-select bit 7 = 0), the request is 0 and the pin readback is 1.
- R2: The pin readback equals the pin input as sampled two clock edges earlier.
- R3: With enable = 1 and edge-select = 0, the request equals the inverse of the pin readback (a low level requests).
- R4: With enable = 1 and edge-select = 1, a high-to-low change of the pin readback raises the request one clock edge later, and a low level alone raises nothing.
- R5: In edge mode the request stays high after the pin returns high, and falls on the clock edge that samples the acknowledge strobe.
- R6: A falling edge that is detected in the same cycle as an acknowledge leaves the request high.
- R7: With enable = 0 the request is 0 and the edge latch is cleared, so an edge seen while disabled raises no request after re-enabling. The pin readback keeps following the pin.
- R8: A control write updates the enable bit in every mode class, and bits 5 to 0 always read as zero.
- R9: The edge-select bit follows every write when the mode class is special (mode_cls[1] = 1). When the mode class is normal (00) or emulation (01), only the first control write after reset can change the bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_n | input | 1 | Asynchronous external interrupt pin, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control write data: bit 7 edge-select, bit 6 enable |
| ack | input | 1 | Interrupt acknowledge strobe, clears the edge latch |
| mode_cls | input | 2 | Mode class: 00 normal, 01 emulation, 1x special |
| irq_req | output | 1 | Interrupt request to the interrupt logic, active high |
| pin_raw | output | 1 | Synchronized pin value for general-purpose reading |
| ctrl_rd | output | 8 | Control register readback |

## Verification
The assertions assume that mode_cls is held constant between resets. They also assume that a control write and an acknowledge never fall in the same cycle as the hold and clear checks they cover. Both of those checks are therefore qualified on wr_en being low. The stimulus sets mode_cls only while reset is asserted, and it changes the pin, writes and acknowledges only at known offsets from the synchronizer. This lets it place a falling edge exactly in the acknowledge cycle. Every mode class is swept against both edge-select settings.

// File: rtl/irqc_pkg.sv
// Shared definitions for the external interrupt input conditioner.
// Assumes an 8-bit control register with two live bits.
package irqc_pkg;
    localparam int REG_W  = 8;
    localparam int EN_BIT = 6;
    localparam int ES_BIT = 7;
    localparam logic [REG_W-1:0] CTRL_RESET = 8'h40;

    typedef enum logic [1:0] {
        MC_NORMAL  = 2'b00,
        MC_EMUL    = 2'b01,
        MC_SPECIAL = 2'b10,
        MC_SPEC_B  = 2'b11
    } mode_cls_e;

    // Special mode classes lift the write-once protection.
    function automatic logic is_special(input logic [1:0] mc);
        return mc[1];
    endfunction
endpackage

// File: rtl/irqc_sync.sv
// Multi-flop synchronizer for an asynchronous, idle-high input.
// Assumes STAGES >= 2. All stages reset to the idle (high) value.
module irqc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/irqc_ctrl.sv
// Control register holding the enable and edge-select bits.
// The enable bit is writable at any time. The edge-select bit is write-once
// after reset unless the mode class is special. Assumes mode_cls is stable
// between resets.
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int EN_B  = EN_BIT,
    parameter int ES_B  = ES_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   mode_cls,
    output logic         enable,
    output logic         edge_sel,
    output logic [W-1:0] rd_data
);
    logic once_used;
    logic es_writable;
    logic unused_bits;

    assign es_writable = is_special(mode_cls) || !once_used;
    assign unused_bits = ^{wr_data, mode_cls[0]};

    // Enable bit: updated by every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= CTRL_RESET[EN_B];
        else if (wr_en) enable <= wr_data[EN_B];
    end

    // Edge-select bit: updated only while the protection allows it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    edge_sel <= CTRL_RESET[ES_B];
        else if (wr_en && es_writable) edge_sel <= wr_data[ES_B];
    end

    // Record that the single permitted write has been spent.
    always_ff @(posedge clk) begin
        if (!rst_n)     once_used <= 1'b0;
        else if (wr_en) once_used <= 1'b1;
    end

    // Assemble the readback; bits that hold nothing read zero.
    for (genvar i = 0; i < W; i++) begin : g_rd
        if (i == EN_B)      begin : g_en assign rd_data[i] = enable;   end
        else if (i == ES_B) begin : g_es assign rd_data[i] = edge_sel; end
        else                begin : g_z  assign rd_data[i] = 1'b0;     end
    end

    // R9: a spent write-once leaves edge-select untouched outside special classes.
    p_once_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (once_used && !mode_cls[1] && wr_en) |=> $stable(edge_sel));
endmodule

// File: rtl/irqc_detect.sv
// Edge detector, edge latch and request selection.
// Input sync_pin is already synchronized and idle-high. The latch works only
// while the block is enabled and in edge mode. A new edge has priority over
// an acknowledge in the same cycle.
module irqc_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pin,
    input  logic enable,
    input  logic edge_sel,
    input  logic ack,
    output logic req
);
    logic prev_pin;
    logic fall;
    logic edge_on;
    logic latch_q;

    assign fall    = prev_pin && !sync_pin;
    assign edge_on = enable && edge_sel;

    // Remember the previous synchronized pin value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_pin <= 1'b1;
        else        prev_pin <= sync_pin;
    end

    // Edge latch: cleared when inactive, set by an edge, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= 1'b0;
        else if (!edge_on) latch_q <= 1'b0;
        else if (fall)     latch_q <= 1'b1;
        else if (ack)      latch_q <= 1'b0;
    end

    // Select the request source by mode.
    always_comb begin
        if (!enable)       req = 1'b0;
        else if (edge_sel) req = latch_q;
        else               req = !sync_pin;
    end

    // R4, R6: an edge seen while active is latched, even under acknowledge.
    p_edge_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_on && fall) |=> (latch_q || !edge_on));

    // R7: a disabled block keeps the latch empty.
    p_latch_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_on |=> (!latch_q || (edge_on && $past(fall))));
endmodule

// File: rtl/irq_input_cond.sv
// Top level of the configurable external interrupt input.
// It chains the synchronizer, the control register and the detector.
// Assumes mode_cls is held constant between resets.
module irq_input_cond
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ack,
    input  logic [1:0]       mode_cls,
    output logic             irq_req,
    output logic             pin_raw,
    output logic [REG_W-1:0] ctrl_rd
);
    logic sync_pin;
    logic enable;
    logic edge_sel;

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_n),
        .dout  (sync_pin)
    );

    irqc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mode_cls (mode_cls),
        .enable   (enable),
        .edge_sel (edge_sel),
        .rd_data  (ctrl_rd)
    );

    irqc_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_pin (sync_pin),
        .enable   (enable),
        .edge_sel (edge_sel),
        .ack      (ack),
        .req      (irq_req)
    );

    assign pin_raw = sync_pin;

    // Cycles since reset, saturating, used to qualify the delay check.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    // R2: readback is the pin two edges late (default two-stage chain).
    p_raw_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (SYNC_STAGES == 2 && since_rst == 2) |-> (pin_raw == $past(pin_n, 2)));

    // R3: level mode requests while the readback is low.
    p_level_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[EN_BIT] && !ctrl_rd[ES_BIT]) |-> (irq_req == !pin_raw));

    // R5: an edge request holds until acknowledged.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[EN_BIT] && ctrl_rd[ES_BIT] && irq_req && !ack && !wr_en) |=> irq_req);

    // R5: an acknowledge with no new edge clears the request.
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[EN_BIT] && ctrl_rd[ES_BIT] && ack && !wr_en && !(pin_raw == 1'b0 && $past(pin_raw) == 1'b1))
        |=> !irq_req);

    // R7: disabled means no request.
    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[EN_BIT] |-> !irq_req);
endmodule

// File: tb/irq_input_cond_bench.sv
// Self-checking sweep over every mode class and both edge-select settings.
module irq_input_cond_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ack = 1'b0;
    logic [1:0] mode_cls = 2'b00;
    logic       irq_req;
    logic       pin_raw;
    logic [7:0] ctrl_rd;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    irq_input_cond u_irq_input_cond (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .wr_en(wr_en),
        .wr_data(wr_data), .ack(ack), .mode_cls(mode_cls),
        .irq_req(irq_req), .pin_raw(pin_raw), .ctrl_rd(ctrl_rd)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mc);
        rst_n = 1'b0; pin_n = 1'b1; wr_en = 1'b0; ack = 1'b0; mode_cls = mc;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(1);
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                logic es;
                logic spec;
                logic exp_es;
                es = e[0];
                spec = m[1];
                do_reset(m[1:0]);
                chk("R1 ctrl", ctrl_rd, 8'h40);
                chk("R1 req", {7'd0, irq_req}, 8'd0);
                chk("R1 raw", {7'd0, pin_raw}, 8'd1);

                wr({es, 1'b1, 6'h3F});
                chk("R8 first write", ctrl_rd, {es, 1'b1, 6'h00});

                pin_n = 1'b0;
                tick(1);
                chk("R2 raw one edge", {7'd0, pin_raw}, 8'd1);
                tick(1);
                chk("R2 raw two edges", {7'd0, pin_raw}, 8'd0);
                if (!es) begin
                    chk("R3 low level", {7'd0, irq_req}, 8'd1);
                    pin_n = 1'b1;
                    tick(2);
                    chk("R3 high level", {7'd0, irq_req}, 8'd0);
                end else begin
                    chk("R4 not yet", {7'd0, irq_req}, 8'd0);
                    tick(1);
                    chk("R4 edge req", {7'd0, irq_req}, 8'd1);
                    pin_n = 1'b1;
                    tick(3);
                    chk("R5 held", {7'd0, irq_req}, 8'd1);
                    ack = 1'b1; tick(1); ack = 1'b0;
                    chk("R5 ack clear", {7'd0, irq_req}, 8'd0);
                    pin_n = 1'b0;
                    tick(2);
                    ack = 1'b1; tick(1); ack = 1'b0;
                    chk("R6 edge with ack", {7'd0, irq_req}, 8'd1);
                    ack = 1'b1; tick(1); ack = 1'b0;
                    chk("R5 ack no edge", {7'd0, irq_req}, 8'd0);
                    tick(2);
                    chk("R4 low no edge", {7'd0, irq_req}, 8'd0);
                    pin_n = 1'b1;
                    tick(3);
                end

                wr({es, 1'b0, 6'h15});
                chk("R8 disable", ctrl_rd, {es, 1'b0, 6'h00});
                pin_n = 1'b0;
                tick(3);
                chk("R7 off req", {7'd0, irq_req}, 8'd0);
                chk("R7 raw readable", {7'd0, pin_raw}, 8'd0);
                pin_n = 1'b1;
                tick(3);
                wr({es, 1'b1, 6'h00});
                chk("R7 latch cleared", {7'd0, irq_req}, 8'd0);

                wr({~es, 1'b1, 6'h00});
                exp_es = spec ? ~es : es;
                chk("R9 flip", ctrl_rd, {exp_es, 1'b1, 6'h00});
                pin_n = 1'b0;
                tick(2);
                chk("R9 mode follows", {7'd0, irq_req}, {7'd0, ~exp_es});
                tick(1);
                chk("R9 req later", {7'd0, irq_req}, 8'd1);
                pin_n = 1'b1;
                tick(3);
                wr({es, 1'b1, 6'h00});
                chk("R9 write back", ctrl_rd, {es, 1'b1, 6'h00});
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule